// File: doc/BRIEF.md
# Serial Receiver with Line-Break Detection

This block receives asynchronous serial frames. A frame is a low start bit, eight data bits sent least significant bit first, an optional ninth bit, and one high stop bit. The block works from a 16x oversampling tick. The start edge is confirmed halfway into the start bit. After that, every bit is taken from one sample at its centre. A good frame presents the byte and the ninth bit and raises a one-clock completion strobe.

The block also watches the line for faults. A stop bit sampled low sets a sticky framing-error flag. A run of eleven consecutive low bit samples, counting from the start bit, sets a sticky break flag and the framing-error flag together. After a break the receiver ignores the line until it has stayed high for one whole bit period. Software clears each flag through its own clear input. A select input chooses what appears on one shared status output: either the framing-error flag, or a mode bit supplied from outside.

Top module: `uart_rx_brk`

## Requirements
- R1: A falling edge on the line starts a frame only if the line is still low at the centre of the start bit, eight ticks after the edge was seen. If the line is high there, the receiver goes back to idle and raises no strobe and no flag.
- R2: Data bits are taken least significant bit first, one centre sample each. When the stop bit samples high, `rx_data` is updated and `rx_done` is high for exactly one clock.
- R3: With `nine_en` = 1, a ninth bit follows the eight data bits and appears on `rx_bit9`. With `nine_en` = 0, `rx_bit9` reads 0.
- R4: A stop bit sampled low sets `fe_flag`, and `rx_done` does not pulse for that frame.
- R5: `brk_flag` is set when eleven consecutive bit samples are low, counting the start bit. Ten low samples followed by a high stop bit do not set it. A break does not pulse `rx_done`.
- R6: `fe_flag` is set no later than the clock in which `brk_flag` is set.
- R7: After a break, no new frame is accepted until the line has been high for 16 consecutive ticks. A shorter high pulse restarts that wait.
- R8: `fe_flag` and `brk_flag` stay set until `clr_fe` or `clr_brk` is pulsed. If a set and a clear arrive in the same cycle, the set wins.
- R9: `shared_bit` equals `fe_flag` when `alias_sel` = 1, and equals `mode_bit` when `alias_sel` = 0.
- R10: After reset, `fe_flag`, `brk_flag` and `rx_done` are 0 and the receiver is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | 16x oversampling enable, one clock wide |
| rxd | input | 1 | Serial line, high when idle |
| nine_en | input | 1 | Expect a ninth bit after the data bits |
| alias_sel | input | 1 | 1: `shared_bit` shows the framing error |
| mode_bit | input | 1 | Value shown on `shared_bit` when `alias_sel` = 0 |
| clr_fe | input | 1 | Clears `fe_flag` |
| clr_brk | input | 1 | Clears `brk_flag` |
| rx_data | output | 8 | Last good byte |
| rx_bit9 | output | 1 | Last good ninth bit |
| rx_done | output | 1 | One-clock strobe for a good frame |
| fe_flag | output | 1 | Sticky framing error |
| brk_flag | output | 1 | Sticky line break |
| shared_bit | output | 1 | Framing error or mode bit, chosen by `alias_sel` |

## Verification
Some properties are checked on every cycle by the assertions:
- the strobe is one clock wide;
- the break flag never rises without the framing-error flag;
- no strobe appears while the receiver waits after a break or in the cycle a break is declared;
- the flags are sticky while no clear is applied.

Other behaviour can only be shown by the bench's scenarios:
- the exact count at which a break is declared: ten low samples against eleven;
- rejection of a start glitch;
- bit order and ninth-bit placement;
- the restart of the post-break wait by a short high pulse.

// File: rtl/uart_rx_brk.sv
module uart_rx_brk #(
  parameter int DATA_BITS = 8,
  parameter int OVS       = 16,
  parameter int BRK_BITS  = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 rxd,
  input  logic                 nine_en,
  input  logic                 alias_sel,
  input  logic                 mode_bit,
  input  logic                 clr_fe,
  input  logic                 clr_brk,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_bit9,
  output logic                 rx_done,
  output logic                 fe_flag,
  output logic                 brk_flag,
  output logic                 shared_bit
);
  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(DATA_BITS + 2);
  localparam int LW = $clog2(BRK_BITS + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_STOP, S_LOW, S_BWAIT} st_t;
  st_t st;

  logic [1:0]         sync;
  logic [CW-1:0]      cnt;
  logic [BW-1:0]      bidx;
  logic [LW-1:0]      lows;
  logic [DATA_BITS:0] sh;

  wire rx_s      = sync[1];
  wire mid_start = tick && cnt == CW'(OVS/2 - 1);
  wire bit_end   = tick && cnt == CW'(OVS - 1);
  wire [LW-1:0] lows_nx = rx_s ? '0 : (lows == LW'(BRK_BITS) ? lows : lows + LW'(1));
  wire [BW-1:0] nbits   = nine_en ? BW'(DATA_BITS + 1) : BW'(DATA_BITS);
  wire brk_now = lows_nx == LW'(BRK_BITS);

  assign shared_bit = alias_sel ? fe_flag : mode_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync     <= 2'b11;
      st       <= S_IDLE;
      cnt      <= '0;
      bidx     <= '0;
      lows     <= '0;
      sh       <= '0;
      rx_data  <= '0;
      rx_bit9  <= 1'b0;
      rx_done  <= 1'b0;
      fe_flag  <= 1'b0;
      brk_flag <= 1'b0;
    end else begin
      sync    <= {sync[0], rxd};
      rx_done <= 1'b0;
      if (clr_fe)  fe_flag  <= 1'b0;
      if (clr_brk) brk_flag <= 1'b0;
      case (st)
        S_IDLE:
          if (tick && !rx_s) begin
            st  <= S_START;
            cnt <= '0;
          end
        S_START:
          if (mid_start) begin
            cnt <= '0;
            if (rx_s) st <= S_IDLE;
            else begin
              st   <= S_DATA;
              bidx <= '0;
              lows <= LW'(1);
            end
          end else if (tick) cnt <= cnt + CW'(1);
        S_DATA:
          if (bit_end) begin
            cnt  <= '0;
            sh   <= {rx_s, sh[DATA_BITS:1]};
            lows <= lows_nx;
            bidx <= bidx + BW'(1);
            if (bidx == nbits - BW'(1)) st <= S_STOP;
          end else if (tick) cnt <= cnt + CW'(1);
        S_STOP, S_LOW:
          if (bit_end) begin
            cnt  <= '0;
            lows <= lows_nx;
            if (rx_s) begin
              st <= S_IDLE;
              if (st == S_STOP) begin
                rx_done <= 1'b1;
                rx_data <= nine_en ? sh[DATA_BITS-1:0] : sh[DATA_BITS:1];
                rx_bit9 <= nine_en & sh[DATA_BITS];
              end
            end else begin
              fe_flag <= 1'b1;
              if (brk_now) begin
                brk_flag <= 1'b1;
                st       <= S_BWAIT;
              end else st <= S_LOW;
            end
          end else if (tick) cnt <= cnt + CW'(1);
        S_BWAIT:
          if (tick) begin
            if (!rx_s) cnt <= '0;
            else if (cnt == CW'(OVS - 1)) begin
              cnt <= '0;
              st  <= S_IDLE;
            end else cnt <= cnt + CW'(1);
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2
  done_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);

  // R6
  brk_with_fe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_flag) |-> fe_flag);

  // R5
  brk_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_flag) |-> !rx_done);

  // R7
  bwait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BWAIT) |=> !rx_done);

  // R8
  fe_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_flag && !clr_fe) |=> fe_flag);

  // R8
  brk_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_flag && !clr_brk) |=> brk_flag);
endmodule

// File: tb/tb_uart_rx_brk.sv
module tb_uart_rx_brk;
  localparam int BITCLK = 64;

  logic clk = 0, rst_n = 0, rxd = 1, nine_en = 0, alias_sel = 0, mode_bit = 0;
  logic clr_fe = 0, clr_brk = 0;
  logic [1:0] tdiv = 0;
  logic [7:0] rx_data;
  logic rx_bit9, rx_done, fe_flag, brk_flag, shared_bit;
  wire tick = (tdiv == 2'd3);
  int n_chk = 0, n_bad = 0, done_cnt = 0;

  always #5 clk = ~clk;
  always @(posedge clk) tdiv <= tdiv + 2'd1;
  always @(negedge clk) if (rst_n && rx_done) done_cnt++;

  uart_rx_brk dut (.clk, .rst_n, .tick, .rxd, .nine_en, .alias_sel, .mode_bit,
    .clr_fe, .clr_brk, .rx_data, .rx_bit9, .rx_done, .fe_flag, .brk_flag, .shared_bit);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic line(logic v, int bits);
    rxd = v;
    repeat (bits * BITCLK) @(negedge clk);
  endtask

  task automatic frame(logic [7:0] d, logic b9, logic use9, logic stop);
    line(0, 1);
    for (int i = 0; i < 8; i++) line(d[i], 1);
    if (use9) line(b9, 1);
    line(stop, 1);
  endtask

  task automatic clear_flags();
    @(negedge clk); clr_fe = 1; clr_brk = 1;
    @(negedge clk); clr_fe = 0; clr_brk = 0;
  endtask

  task automatic t_reset();
    check("R10 fe", fe_flag, 0);
    check("R10 brk", brk_flag, 0);
    check("R10 done", rx_done, 0);
    mode_bit = 1; alias_sel = 0; @(negedge clk);
    check("R9 mode alias", shared_bit, 1);
  endtask

  task automatic t_normal();
    int c0 = done_cnt;
    nine_en = 0;
    frame(8'hA5, 0, 0, 1); line(1, 1);
    check("R2 data A5", rx_data, 8'hA5);
    check("R2 one strobe", done_cnt - c0, 1);
    check("R3 bit9 off", rx_bit9, 0);
    check("R4 no fe", fe_flag, 0);
  endtask

  task automatic t_ninth();
    int c0 = done_cnt;
    nine_en = 1;
    frame(8'h3C, 1, 1, 1); line(1, 1);
    check("R3 data 3C", rx_data, 8'h3C);
    check("R3 bit9", rx_bit9, 1);
    check("R3 strobe", done_cnt - c0, 1);
    nine_en = 0;
  endtask

  task automatic t_glitch();
    int c0 = done_cnt;
    rxd = 0; repeat (16) @(negedge clk);
    line(1, 2);
    check("R1 glitch no strobe", done_cnt - c0, 0);
    check("R1 glitch no fe", fe_flag, 0);
    frame(8'h5A, 0, 0, 1); line(1, 1);
    check("R1 next frame", rx_data, 8'h5A);
    check("R1 next strobe", done_cnt - c0, 1);
  endtask

  task automatic t_ten_lows();
    int c0 = done_cnt;
    nine_en = 1;
    frame(8'h00, 0, 1, 1); line(1, 1);
    check("R5 ten lows no brk", brk_flag, 0);
    check("R5 ten lows strobe", done_cnt - c0, 1);
    nine_en = 0;
  endtask

  task automatic t_bad_stop();
    int c0 = done_cnt;
    frame(8'h81, 0, 0, 0); line(1, 2);
    check("R4 fe set", fe_flag, 1);
    check("R4 no strobe", done_cnt - c0, 0);
    check("R5 no brk", brk_flag, 0);
    line(1, 3);
    check("R8 fe held", fe_flag, 1);
    alias_sel = 1; mode_bit = 0; @(negedge clk);
    check("R9 fe alias", shared_bit, 1);
    alias_sel = 0; @(negedge clk);
    check("R9 mode alias", shared_bit, 0);
    clear_flags();
    check("R8 fe cleared", fe_flag, 0);
  endtask

  task automatic t_break9();
    nine_en = 1;
    frame(8'h00, 0, 1, 0);
    check("R5 brk at eleventh low", brk_flag, 1);
    check("R6 fe with brk", fe_flag, 1);
    line(1, 2);
    nine_en = 0;
    clear_flags();
  endtask

  task automatic t_break();
    int c0 = done_cnt;
    line(0, 12);
    check("R5 brk set", brk_flag, 1);
    check("R6 fe set", fe_flag, 1);
    check("R5 no strobe", done_cnt - c0, 0);
    clear_flags();
    rxd = 1; repeat (8) @(negedge clk);
    line(0, 3);
    line(1, 2);
    check("R7 short high ignored", done_cnt - c0, 0);
    check("R7 no new fe", fe_flag, 0);
    check("R8 brk cleared", brk_flag, 0);
    frame(8'h42, 0, 0, 1); line(1, 1);
    check("R7 resume data", rx_data, 8'h42);
    check("R7 resume strobe", done_cnt - c0, 1);
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        repeat (4) @(negedge clk);
        t_reset();
        t_normal();
        t_ninth();
        t_glitch();
        t_ten_lows();
        t_bad_stop();
        t_break9();
        t_break();
      end
      begin
        repeat (150000) @(negedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule